// File: doc/BRIEF.md
# Four-output PWM group with shared period counter

This block drives four pulse-width-modulated outputs, organised as two pairs, from one period counter. The counter runs either in edge-aligned form, counting up and wrapping, or in center-aligned form, counting up to the period value and back down. Each pair is either complementary, where the second output is the logical inverse of the first, or independent, where each output compares against its own duty value. Motor-control firmware programs the period, the mode and four duty values through a simple register write port. A single-cycle sync output marks the start of every PWM cycle, and it also marks the midpoint when the double-reload mode is active.

All writes land in shadow registers. The shadow copies move into the active copies only at defined reload points: the cycle start, and in center-aligned double-reload mode also the midpoint. While the enable input is low the group is idle. All outputs stay low, the counter is held at zero, and the active copies follow the shadows. When enable rises, a fresh cycle begins from zero with the programmed values.

The write port is a plain strobe with no back-pressure. A write is accepted on every clock edge where `wr_en` is high, and the block never stalls it.

Top module: `pwm_quad_gen`

## Requirements
- R1: During reset with `en` low, all outputs are low. After reset the active values are period 100, mode 0 and all duties 0, so with `en` high pair outputs read `pwm_o = 4'b1010` and `sync_o` is high in the first cycle.
- R2: Edge-aligned mode (mode bit 0 clear) counts 0,1,...,P-1 and then wraps, so one cycle lasts P clocks. `sync_o` is high exactly when the count is 0.
- R3: Center-aligned mode (mode bit 0 set) counts 0,1,...,P in the rising half and P-1,...,1 in the falling half, so one cycle lasts 2P clocks. `sync_o` is high when the count is 0.
- R4: In the rising half an output is high iff count < duty. In the falling half it is high iff count <= duty, so each half carries the same number of high clocks for a constant duty.
- R5: A duty of 0 gives a constant low output, and a duty of P or more gives a constant high output.
- R6: When a pair's independent bit is clear (mode bit 2 for pair 0, bit 3 for pair 1), the odd output of the pair is the inverse of the even output while `en` is high.
- R7: When a pair's independent bit is set, the odd output compares the count against its own duty register.
- R8: Active period, mode and duties reload from the shadows only on the clock edge that returns the count to 0. Writes made in between have no effect until then.
- R9: In center-aligned mode with mode bit 1 set, the duties also reload on the edge that brings the count to P, and `sync_o` is high during that count-P clock.
- R10: Mode bit 1 has no effect in edge-aligned mode.
- R11: A write that falls on the same clock edge as a reload is not taken by that reload. It appears at the next reload.
- R12: While `en` is low, `pwm_o` and `sync_o` are low, the count is held at 0 and the active values follow the shadows. After `en` rises, the first clock is count 0.
- R13: A period value of 0 behaves as a period of 1.
- Register map (`wr_addr`): 0 holds the period, 1 holds the mode, and 2 to 5 hold the duties of outputs 0 to 3. Addresses 6 and 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable; low holds the group idle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | CW (8) | Register write data |
| pwm_o | output | 4 | PWM outputs; pair 0 is bits 1:0, pair 1 is bits 3:2 |
| sync_o | output | 1 | Cycle start pulse, plus the midpoint pulse in double-reload mode |

## Verification
Two events can fall on the same clock edge: a register write from software and a reload of the active copies. With small periods a reload happens on almost every edge, so the collision occurs naturally. The bench writes four new duty values on the first four clocks after enable, in every mode and for periods 0 to 4. For each output it then works out arithmetically whether any reload edge came strictly after that output's write. Each sampled output is compared against the old or new duty on that basis, which judges both the collision rule and the midpoint reload.

// File: rtl/pwm_quad_pkg.sv
package pwm_quad_pkg;
  localparam int NPAIR  = 2;
  localparam int NOUT   = 2 * NPAIR;
  localparam int AW     = 3;
  localparam int MODE_W = 2 + NPAIR;

  localparam logic [AW-1:0] ADDR_PERIOD = 3'd0;
  localparam logic [AW-1:0] ADDR_MODE   = 3'd1;
  localparam logic [AW-1:0] ADDR_DUTY0  = 3'd2;

  // bit0 center, bit1 twice, bits 2.. per-pair independent
  typedef struct packed {
    logic [NPAIR-1:0] solo;
    logic             twice;
    logic             center;
  } mode_t;
endpackage

// File: rtl/pwm_quad_counter.sv
module pwm_quad_counter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] per,
  input  logic          center,
  input  logic          twice,
  output logic [CW-1:0] cnt,
  output logic          down,
  output logic [CW-1:0] per_eff,
  output logic          ld_start,
  output logic          ld_mid
);
  logic [CW-1:0] cnt_nxt;
  logic          down_nxt;
  logic          wrap;
  logic          mid;

  assign per_eff = (per == '0) ? CW'(1) : per;

  always_comb begin
    cnt_nxt  = cnt;
    down_nxt = down;
    wrap     = 1'b0;
    mid      = 1'b0;
    if (!center) begin
      down_nxt = 1'b0;
      if (cnt >= per_eff - 1'b1) begin
        cnt_nxt = '0;
        wrap    = 1'b1;
      end else begin
        cnt_nxt = cnt + 1'b1;
      end
    end else if (!down) begin
      if (cnt >= per_eff - 1'b1) begin
        cnt_nxt  = per_eff;
        down_nxt = 1'b1;
        mid      = 1'b1;
      end else begin
        cnt_nxt = cnt + 1'b1;
      end
    end else begin
      if (cnt <= CW'(1)) begin
        cnt_nxt  = '0;
        down_nxt = 1'b0;
        wrap     = 1'b1;
      end else begin
        cnt_nxt = cnt - 1'b1;
      end
    end
  end

  assign ld_start = en & wrap;
  assign ld_mid   = en & mid & twice;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      cnt  <= '0;
      down <= 1'b0;
    end else begin
      cnt  <= cnt_nxt;
      down <= down_nxt;
    end
  end
endmodule

// File: rtl/pwm_quad_regs.sv
module pwm_quad_regs
  import pwm_quad_pkg::*;
#(
  parameter int            CW      = 8,
  parameter logic [CW-1:0] DEF_PER = CW'(100)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic                     wr_en,
  input  logic [AW-1:0]            wr_addr,
  input  logic [CW-1:0]            wr_data,
  input  logic                     ld_start,
  input  logic                     ld_mid,
  output logic [CW-1:0]            per_act,
  output mode_t                    mode_act,
  output logic [NOUT-1:0][CW-1:0]  duty_act
);
  logic [CW-1:0]           per_sh;
  mode_t                   mode_sh;
  logic [NOUT-1:0][CW-1:0] duty_sh;
  logic                    full_ld;

  assign full_ld = !en || ld_start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_sh  <= DEF_PER;
      mode_sh <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_PERIOD) per_sh  <= wr_data;
      if (wr_addr == ADDR_MODE)   mode_sh <= mode_t'(wr_data[MODE_W-1:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_act  <= DEF_PER;
      mode_act <= '0;
    end else if (full_ld) begin
      per_act  <= per_sh;
      mode_act <= mode_sh;
    end
  end

  for (genvar i = 0; i < NOUT; i++) begin : g_duty
    localparam logic [AW-1:0] MY_ADDR = ADDR_DUTY0 + AW'(i);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        duty_sh[i] <= '0;
      end else if (wr_en && wr_addr == MY_ADDR) begin
        duty_sh[i] <= wr_data;
      end
    end
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        duty_act[i] <= '0;
      end else if (full_ld || ld_mid) begin
        duty_act[i] <= duty_sh[i];
      end
    end
  end
endmodule

// File: rtl/pwm_quad_out.sv
module pwm_quad_out
  import pwm_quad_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic                    en,
  input  logic [CW-1:0]           cnt,
  input  logic                    down,
  input  logic [NOUT-1:0][CW-1:0] duty,
  input  logic [NPAIR-1:0]        solo,
  output logic [NOUT-1:0]         pwm
);
  logic [NOUT-1:0] hit;

  for (genvar i = 0; i < NOUT; i++) begin : g_cmp
    assign hit[i] = down ? (cnt <= duty[i]) : (cnt < duty[i]);
  end

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    assign pwm[2*p]   = en & hit[2*p];
    assign pwm[2*p+1] = en & (solo[p] ? hit[2*p+1] : ~hit[2*p]);
  end
endmodule

// File: rtl/pwm_quad_gen.sv
module pwm_quad_gen
  import pwm_quad_pkg::*;
#(
  parameter int            CW      = 8,
  parameter logic [CW-1:0] DEF_PER = CW'(100)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  output logic [3:0]    pwm_o,
  output logic          sync_o
);
  logic [CW-1:0]           cnt;
  logic                    down;
  logic [CW-1:0]           per_eff;
  logic                    ld_start;
  logic                    ld_mid;
  logic [CW-1:0]           per_act;
  mode_t                   mode_act;
  logic [NOUT-1:0][CW-1:0] duty_act;

  pwm_quad_regs #(.CW(CW), .DEF_PER(DEF_PER)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .ld_start (ld_start),
    .ld_mid   (ld_mid),
    .per_act  (per_act),
    .mode_act (mode_act),
    .duty_act (duty_act)
  );

  pwm_quad_counter #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .per      (per_act),
    .center   (mode_act.center),
    .twice    (mode_act.twice),
    .cnt      (cnt),
    .down     (down),
    .per_eff  (per_eff),
    .ld_start (ld_start),
    .ld_mid   (ld_mid)
  );

  pwm_quad_out #(.CW(CW)) u_out (
    .en   (en),
    .cnt  (cnt),
    .down (down),
    .duty (duty_act),
    .solo (mode_act.solo),
    .pwm  (pwm_o)
  );

  assign sync_o = en & ((cnt == '0) |
                  (mode_act.center & mode_act.twice & down & (cnt == per_eff)));
endmodule

// File: rtl/pwm_quad_chk.sv
module pwm_quad_chk
  import pwm_quad_pkg::*;
#(
  parameter int CW = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    en,
  input logic [3:0]              pwm_o,
  input logic                    sync_o,
  input logic [CW-1:0]           cnt,
  input logic [CW-1:0]           per_eff,
  input mode_t                   mode,
  input logic [NOUT-1:0][CW-1:0] duty,
  input logic                    ld_start,
  input logic                    ld_mid
);
  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (pwm_o == 4'b0000 && !sync_o));

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= per_eff);

  // R2
  edge_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !mode.center) |=> (cnt == $past(cnt) + 1'b1 || cnt == '0));

  // R6
  pair_comp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !mode.solo[0]) |-> (pwm_o[1] != pwm_o[0]));

  // R8
  duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !ld_start && !ld_mid) |=> $stable(duty));

  // R10
  mid_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_mid |-> (mode.center && mode.twice));

  // R9
  mid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_mid |=> (sync_o || !en));
endmodule

bind pwm_quad_gen pwm_quad_chk #(.CW(CW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (en),
  .pwm_o    (pwm_o),
  .sync_o   (sync_o),
  .cnt      (cnt),
  .per_eff  (per_eff),
  .mode     (mode_act),
  .duty     (duty_act),
  .ld_start (ld_start),
  .ld_mid   (ld_mid)
);

// File: tb/pwm_quad_gen_bench.sv
`timescale 1ns/1ps
module pwm_quad_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = 3'd0;
  logic [7:0] wr_data = 8'd0;
  logic [3:0] pwm_o;
  logic       sync_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pwm_quad_gen u_pwm_quad_gen (
    .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .pwm_o(pwm_o), .sync_o(sync_o)
  );

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // mode: 0 edge, 1 edge with twice bit, 2 center single, 3 center double
  function automatic bit reload_at(int j, int mode, int pe, int len);
    if (mode == 3) return ((j + 1) % pe) == 0;
    return ((j + 1) % len) == 0;
  endfunction

  function automatic bit new_seen(int w, int k, int mode, int pe, int len);
    for (int j = w + 1; j < k; j++)
      if (reload_at(j, mode, pe, len)) return 1'b1;
    return 1'b0;
  endfunction

  task automatic run(int p, int mode, int pair);
    int pe, len, nsamp, cnt, dn, modebits;
    int a[4];
    int b[4];
    pe  = (p == 0) ? 1 : p;
    len = (mode >= 2) ? 2 * pe : pe;
    nsamp = 4 * len + 4;
    for (int i = 0; i < 4; i++) begin
      a[i] = (i * 3 + p + mode) % (pe + 2);
      b[i] = (i * 5 + 1 + pair + mode) % (pe + 2);
    end
    modebits = (pair << 2) | ((mode == 1 || mode == 3) ? 2 : 0) | ((mode >= 2) ? 1 : 0);
    wr(0, p);
    wr(1, modebits);
    for (int i = 0; i < 4; i++) wr(2 + i, a[i]);
    @(negedge clk);
    for (int k = 0; k < nsamp; k++) begin
      int m, expsync;
      string stag;
      @(negedge clk);
      en = 1'b1;
      wr_en   = (k < 4);
      wr_addr = 3'(2 + k);
      wr_data = (k < 4) ? 8'(b[k]) : 8'd0;
      #1;
      m = k % len;
      if (mode < 2 || m < pe) begin cnt = m; dn = 0; end
      else begin cnt = 2 * pe - m; dn = 1; end
      expsync = (cnt == 0 || (mode == 3 && dn == 1 && cnt == pe)) ? 1 : 0;
      stag = (p == 0) ? "R13" : (mode < 2) ? "R2" : (mode == 2) ? "R3" : "R9";
      check(stag, int'(sync_o), expsync);
      for (int i = 0; i < 4; i++) begin
        int src, d, hit, expo, solo;
        string otag;
        solo = (pair >> (i / 2)) & 1;
        src  = (i % 2 == 1 && solo == 0) ? i - 1 : i;
        d    = new_seen(src, k, mode, pe, len) ? b[src] : a[src];
        hit  = (dn == 1) ? int'(cnt <= d) : int'(cnt < d);
        expo = (src != i) ? 1 - hit : hit;
        if (src != i)                     otag = "R6";
        else if (d == 0 || d >= pe)       otag = "R5";
        else if (i % 2 == 1)              otag = "R7";
        else if (reload_at(src, mode, pe, len)) otag = "R11";
        else if (mode == 1)               otag = "R10";
        else if (mode == 3)               otag = "R9";
        else if (mode == 2)               otag = "R8";
        else                              otag = "R4";
        check(otag, int'(pwm_o[i]), expo);
      end
    end
    @(negedge clk);
    wr_en = 1'b0;
    en = 1'b0;
    #1;
    // R12: idle outputs quiet
    check("R12", int'({sync_o, pwm_o}), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1: reset with en low
    check("R1", int'({sync_o, pwm_o}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    en = 1'b1;
    #1;
    // R1: defaults, complementary pairs with duty 0
    check("R1", int'(pwm_o), 4'b1010);
    check("R1", int'(sync_o), 1);
    @(negedge clk);
    #1;
    check("R1", int'(sync_o), 0);
    @(negedge clk);
    en = 1'b0;
    for (int p = 0; p <= 4; p++)
      for (int mode = 0; mode < 4; mode++)
        for (int pair = 0; pair < 4; pair++)
          run(p, mode, pair);
    // R12: address 6 and 7 ignored, then idle restart from zero
    wr(6, 255);
    wr(7, 255);
    @(negedge clk);
    en = 1'b1;
    #1;
    check("R12", int'(sync_o), 1);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule